// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block sits behind a Reed-Solomon decoder that works on 12-bit symbols packed into a byte-organised flash page buffer. The decoder hands it a short list of corrections, each a symbol position and a 12-bit error pattern. The block turns each correction into one or two byte addresses with XOR masks. It then patches the buffer through a single-port, byte-wide memory port, using a read followed by a write for every byte it touches.

The buffer is addressed linearly. Addresses 0 to 2047 hold the page data. Address 2048+k holds spare-area byte k. Symbols are 12 bits wide and cross byte boundaries. The exceptions are symbol 0, which carries only 8 data bits, and symbol 1365, which has its upper 8 bits in the last data byte and its low nibble in the first spare byte. Corrections arrive on a valid/ready stream. While a patch is in progress, `corr_ready` is held low, and the producer must keep `corr_valid` and the payload steady until a cycle in which both are high.

The `corr_last` flag ends a page. One cycle after the final correction of the page has been dealt with, `done` pulses. `fail` and `fixed_count` then give the page verdict, and they keep it until the first correction of the next page is accepted.

Top module: `rsfix_applier`

## Requirements
- R1: After reset, `corr_ready` is 1 and `done`, `fail`, `fixed_count` and `mem_en` are all 0.
- R2: A correction is taken on a cycle where `corr_valid` and `corr_ready` are both high. After an accepted correction that is applied, `corr_ready` stays low for 2 cycles if one byte is patched and for 4 cycles if two bytes are patched. After a rejected correction, `corr_ready` stays high.
- R3: For an odd position p, byte floor(3p/2) is XORed with pattern[11:4], and the next byte is XORed with {pattern[3:0], 4'b0000}.
- R4: For an even position p other than 0, byte 3p/2-1 is XORed with {4'b0000, pattern[11:8]}, and byte 3p/2 is XORed with pattern[7:0].
- R5: At position 0, byte 0 is XORed with pattern[7:0] when pattern[11:8] is zero. Otherwise the correction is rejected and no byte changes.
- R6: A position above 1374 is rejected, and no memory access follows it.
- R7: Position 1365 patches data byte 2047 with pattern[11:4] and spare byte 0 (address 2048) with {pattern[3:0], 4'b0000}.
- R8: Positions 1366 to 1374 follow the R3/R4 rules. The resulting byte index minus 2048 is the spare-area byte, at address 2048 plus that index, so every address stays below 2112.
- R9: `done` is high for exactly one cycle per page. For a page whose last correction was rejected, that cycle is the one right after acceptance. Otherwise it is the cycle right after the final write.
- R10: At `done`, `fixed_count` equals the number of corrections applied in the page, and `fail` is 1 if any correction in the page was rejected. When `fail` is 1, `fixed_count` reads 0. Both values hold until the next page's first acceptance, which clears them.
- R11: A page takes at most 4 corrections. The fifth and later ones are accepted and consumed but rejected, and they fail the page. Corrections that follow a rejection are still applied when they are valid.
- R12: Each memory write goes to the address that was read in the cycle before, and the write data is the read data XOR the mask. The memory returns read data one cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_valid | input | 1 | Correction offered |
| corr_ready | output | 1 | Block can take a correction |
| corr_pos | input | 12 | Symbol position |
| corr_pat | input | 12 | Error pattern |
| corr_last | input | 1 | Final correction of the page |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Buffer byte address |
| mem_wdata | output | 8 | Patched byte |
| mem_rdata | input | 8 | Byte read, valid one cycle after a read |
| done | output | 1 | Page finished pulse |
| fail | output | 1 | Page uncorrectable |
| fixed_count | output | 3 | Symbols corrected in the page |

## Verification
An error in the symbol-to-byte mapping leaves a patched byte that differs from the expected buffer, and this is detected when that page's `done` pulses. A wrong engine state shows up as a `corr_ready` or `done` value that disagrees with the cycle-exact model in the very clock it happens. An error in the page tally, such as a counter that does not clear or a failure that does not stick, shows as a wrong `fixed_count` or `fail` at that page's `done`. The stimulus covers the packing corners: symbol 0, the straddling symbol 1365, the highest spare symbol 1374, out-of-range positions, and pages that overflow the correction limit.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYM_W  = 12;
  localparam int unsigned DEF_PAGE_BYTES  = 2048;
  localparam int unsigned DEF_SPARE_BYTES = 64;
  localparam int unsigned DEF_MAX_POS     = 1374;
  localparam int unsigned DEF_MAX_CORR    = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_WR_A = 3'd2,
    ST_RD_B = 3'd3,
    ST_WR_B = 3'd4
  } rmw_state_e;

  // XOR masks for the (up to) two bytes a symbol covers
  typedef struct packed {
    logic [BYTE_W-1:0] mask_a;
    logic [BYTE_W-1:0] mask_b;
    logic              pair;
    logic              reject;
  } lane_plan_t;
endpackage

// File: rtl/rsfix_mapper.sv
module rsfix_mapper
  import rsfix_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned MAX_POS = DEF_MAX_POS
) (
  input  logic [SYM_W-1:0] pos,
  input  logic [SYM_W-1:0] pat,
  input  logic             over_limit,
  output logic [AW-1:0]    base_addr,
  output lane_plan_t       plan
);
  localparam int unsigned TW = SYM_W + 1;

  logic [TW-1:0] tri_idx;
  logic [TW-1:0] base_w;
  logic          pos_zero;
  logic          pos_high;
  logic          narrow_bad;

  // floor(3p/2) = p + floor(p/2)
  assign tri_idx    = {1'b0, pos} + {2'b00, pos[SYM_W-1:1]};
  assign pos_zero   = (pos == '0);
  assign pos_high   = (32'(pos) > MAX_POS);
  assign narrow_bad = pos_zero && (pat[SYM_W-1:BYTE_W] != '0);

  always_comb begin
    plan   = '0;
    base_w = '0;
    if (pos_zero) begin
      base_w      = '0;
      plan.mask_a = pat[BYTE_W-1:0];
      plan.mask_b = '0;
      plan.pair   = 1'b0;
    end else if (pos[0]) begin
      base_w      = tri_idx;
      plan.mask_a = pat[SYM_W-1:4];
      plan.mask_b = {pat[3:0], 4'h0};
      plan.pair   = 1'b1;
    end else begin
      base_w      = tri_idx - TW'(1);
      plan.mask_a = {4'h0, pat[SYM_W-1:BYTE_W]};
      plan.mask_b = pat[BYTE_W-1:0];
      plan.pair   = 1'b1;
    end
    plan.reject = pos_high || narrow_bad || over_limit;
  end

  assign base_addr = AW'(base_w);
endmodule

// File: rtl/rsfix_rmw.sv
module rsfix_rmw
  import rsfix_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     base_in,
  input  lane_plan_t        plan_in,
  output logic              busy,
  output logic              fin,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  rmw_state_e        state_q, state_d;
  logic [AW-1:0]     base_q;
  logic [BYTE_W-1:0] mask_a_q, mask_b_q;
  logic              pair_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_RD_A;
      ST_RD_A: state_d = ST_WR_A;
      ST_WR_A: state_d = pair_q ? ST_RD_B : ST_IDLE;
      ST_RD_B: state_d = ST_WR_B;
      ST_WR_B: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
      pair_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) begin
        base_q   <= base_in;
        mask_a_q <= plan_in.mask_a;
        mask_b_q <= plan_in.mask_b;
        pair_q   <= plan_in.pair;
      end
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = base_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD_A: mem_en = 1'b1;
      ST_WR_A: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata ^ mask_a_q;
      end
      ST_RD_B: begin
        mem_en   = 1'b1;
        mem_addr = base_q + AW'(1);
      end
      ST_WR_B: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + AW'(1);
        mem_wdata = mem_rdata ^ mask_b_q;
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign fin  = (state_q == ST_WR_B) || (state_q == ST_WR_A && !pair_q);
endmodule

// File: rtl/rsfix_tally.sv
module rsfix_tally
  import rsfix_pkg::*;
#(
  parameter int unsigned MAX_CORR = DEF_MAX_CORR,
  parameter int unsigned CNT_W    = $clog2(MAX_CORR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             last,
  input  logic             reject,
  input  logic             fin,
  output logic             over_limit,
  output logic [CNT_W-1:0] fixed_count,
  output logic             fail,
  output logic             done
);
  logic             page_open;
  logic [CNT_W-1:0] seen_q, applied_q;
  logic             failed_q, pend_last_q, done_q;
  logic             page_start;
  logic [CNT_W-1:0] seen_base, applied_base;
  logic             failed_base;

  assign page_start   = !page_open;
  assign seen_base    = page_start ? '0 : seen_q;
  assign applied_base = page_start ? '0 : applied_q;
  assign failed_base  = page_start ? 1'b0 : failed_q;
  assign over_limit   = page_open && (32'(seen_q) >= MAX_CORR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open   <= 1'b0;
      seen_q      <= '0;
      applied_q   <= '0;
      failed_q    <= 1'b0;
      pend_last_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= (accept && last && reject) || (fin && pend_last_q);
      if (fin) pend_last_q <= 1'b0;
      if (accept) begin
        page_open <= !last;
        seen_q    <= (32'(seen_base) < MAX_CORR) ? seen_base + CNT_W'(1) : seen_base;
        applied_q <= applied_base + CNT_W'(!reject);
        failed_q  <= failed_base | reject;
        if (!reject) pend_last_q <= last;
      end
    end
  end

  assign fixed_count = failed_q ? '0 : applied_q;
  assign fail        = failed_q;
  assign done        = done_q;
endmodule

// File: rtl/rsfix_applier.sv
module rsfix_applier
  import rsfix_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = DEF_PAGE_BYTES,
  parameter int unsigned SPARE_BYTES = DEF_SPARE_BYTES,
  parameter int unsigned MAX_POS     = DEF_MAX_POS,
  parameter int unsigned MAX_CORR    = DEF_MAX_CORR,
  parameter int unsigned AW          = $clog2(PAGE_BYTES + SPARE_BYTES),
  parameter int unsigned CNT_W       = $clog2(MAX_CORR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              corr_valid,
  output logic              corr_ready,
  input  logic [SYM_W-1:0]  corr_pos,
  input  logic [SYM_W-1:0]  corr_pat,
  input  logic              corr_last,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  fixed_count
);
  logic          busy, fin, accept, over_limit;
  logic [AW-1:0] base_addr;
  lane_plan_t    plan;

  assign corr_ready = !busy;
  assign accept     = corr_valid && corr_ready;

  rsfix_mapper #(.AW(AW), .MAX_POS(MAX_POS)) u_map (
    .pos(corr_pos), .pat(corr_pat), .over_limit(over_limit),
    .base_addr(base_addr), .plan(plan)
  );

  rsfix_rmw #(.AW(AW)) u_rmw (
    .clk(clk), .rst_n(rst_n), .go(accept && !plan.reject),
    .base_in(base_addr), .plan_in(plan), .busy(busy), .fin(fin),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  rsfix_tally #(.MAX_CORR(MAX_CORR), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .accept(accept), .last(corr_last),
    .reject(plan.reject), .fin(fin), .over_limit(over_limit),
    .fixed_count(fixed_count), .fail(fail), .done(done)
  );
endmodule

// File: rtl/rsfix_applier_chk.sv
module rsfix_applier_chk #(
  parameter int unsigned AW        = 12,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned BUF_BYTES = 2112,
  parameter int unsigned MAX_POS   = 1374,
  parameter int unsigned MAX_CORR  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             corr_valid,
  input logic             corr_ready,
  input logic [11:0]      corr_pos,
  input logic             mem_en,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] fixed_count
);
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr))); // R12
  AST_NO_READY_WHILE_PATCHING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !corr_ready); // R2
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_valid && !corr_ready) |=> (corr_valid && $stable(corr_pos))); // R2
  AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_valid && corr_ready && 32'(corr_pos) > MAX_POS) |=> !mem_en); // R6
  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (32'(mem_addr) < BUF_BYTES)); // R8
  AST_FAIL_HIDES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (fixed_count == '0)); // R10
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fixed_count) <= MAX_CORR); // R11
endmodule

bind rsfix_applier rsfix_applier_chk #(
  .AW(AW), .CNT_W(CNT_W), .BUF_BYTES(PAGE_BYTES + SPARE_BYTES),
  .MAX_POS(MAX_POS), .MAX_CORR(MAX_CORR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_ready(corr_ready),
  .corr_pos(corr_pos), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .done(done), .fail(fail), .fixed_count(fixed_count)
);

// File: tb/rsfix_applier_tb.sv
`timescale 1ns/100ps
module rsfix_applier_tb;
  localparam int BUF = 2112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        corr_valid = 1'b0;
  logic        corr_ready;
  logic [11:0] corr_pos = '0;
  logic [11:0] corr_pat = '0;
  logic        corr_last = 1'b0;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done, fail;
  logic [2:0]  fixed_count;

  logic [7:0] mem     [BUF];
  logic [7:0] ref_mem [BUF];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rsfix_applier u_dut (
    .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_ready(corr_ready),
    .corr_pos(corr_pos), .corr_pat(corr_pat), .corr_last(corr_last),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fixed_count(fixed_count)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // ---------------- behavioural reference model ----------------
  int rem = 0;
  bit pend_last = 0, exp_done = 0, page_open = 0, m_failed = 0;
  int seen = 0, applied = 0;
  int exp_count = 0;
  bit exp_fail = 0;

  function automatic bit rejected(int p, int pt, int n_seen);
    return (n_seen >= 4) || (p > 1374) || (p == 0 && pt > 255);
  endfunction

  task automatic ref_apply(int p, int pt);
    int a;
    if (p == 0) begin
      ref_mem[0] = ref_mem[0] ^ 8'(pt);
    end else if (p % 2 == 1) begin          // R3, R7
      a = (3 * p) / 2;
      ref_mem[a]   = ref_mem[a]   ^ 8'(pt >> 4);
      ref_mem[a+1] = ref_mem[a+1] ^ 8'((pt & 15) << 4);
    end else begin                          // R4
      a = (3 * p) / 2 - 1;
      ref_mem[a]   = ref_mem[a]   ^ 8'(pt >> 8);
      ref_mem[a+1] = ref_mem[a+1] ^ 8'(pt & 255);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; pend_last = 0; exp_done = 0; page_open = 0;
      m_failed = 0; seen = 0; applied = 0; exp_count = 0; exp_fail = 0;
    end else begin
      exp_done = 0;
      if (rem > 0) begin
        rem = rem - 1;
        if (rem == 0 && pend_last) begin exp_done = 1; pend_last = 0; end
      end else if (corr_valid) begin
        if (!page_open) begin seen = 0; applied = 0; m_failed = 0; end
        page_open = !corr_last;
        if (rejected(int'(corr_pos), int'(corr_pat), seen)) begin
          m_failed = 1;
          if (corr_last) exp_done = 1;
        end else begin
          applied = applied + 1;
          ref_apply(int'(corr_pos), int'(corr_pat));
          rem = (corr_pos == 0) ? 2 : 4;
          pend_last = corr_last;
        end
        seen = seen + 1;
        exp_fail  = m_failed;
        exp_count = m_failed ? 0 : applied;
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (corr_ready !== (rem == 0)) begin
        fails++;
        $display("FAIL R2 corr_ready actual=%0b expected=%0b", corr_ready, rem == 0);
      end
      checks++;
      if (done !== exp_done) begin
        fails++;
        $display("FAIL R9 done actual=%0b expected=%0b", done, exp_done);
      end
      if (exp_done) begin
        checks++;
        if (fail !== exp_fail || int'(fixed_count) != exp_count) begin
          fails++;
          $display("FAIL R10 fail/count actual=%0b/%0d expected=%0b/%0d",
                   fail, fixed_count, exp_fail, exp_count);
        end
        checks++;
        begin
          int bad = -1;
          for (int i = 0; i < BUF; i++)
            if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
          if (bad >= 0) begin
            fails++;
            $display("FAIL R3-mapping byte %0d actual=%02h expected=%02h (R4 R5 R7 R8 R12)",
                     bad, mem[bad], ref_mem[bad]);
          end
        end
      end
    end
  end

  task automatic send(int p, int pt, bit last);
    @(negedge clk);
    corr_valid = 1'b1;
    corr_pos   = 12'(p);
    corr_pat   = 12'(pt);
    corr_last  = last;
    while (!corr_ready) @(negedge clk);
    @(negedge clk);
    corr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < BUF; i++) begin
      mem[i]     = 8'((i * 37 + 5) & 255);
      ref_mem[i] = 8'((i * 37 + 5) & 255);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    checks++;                                  // R1 reset state
    if (corr_ready !== 1'b1 || done !== 1'b0 || fail !== 1'b0 ||
        fixed_count !== 3'd0 || mem_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=r%0b d%0b f%0b c%0d e%0b expected=r1 d0 f0 c0 e0",
               corr_ready, done, fail, fixed_count, mem_en);
    end

    send(5, 'hABC, 1); settle();                 // R3 odd
    send(4, 'h5A3, 0);                           // R4 even
    send(0, 'h07E, 0);                           // R5 narrow ok
    send(1365, 'hFFF, 1); settle();              // R7 straddle
    send(1366, 'h123, 0);                        // R8 spare even
    send(1374, 'h9F1, 0);                        // R8 highest
    send(1367, 'h456, 1); settle();              // R8 spare odd
    send(1375, 'h001, 0);                        // R6 out of range
    send(10, 'h111, 1); settle();                // R11 still consumed
    send(0, 'h100, 1); settle();                 // R5 rejected, R9 immediate done
    send(2, 'h0F0, 0); send(3, 'h00F, 0);
    send(6, 'hA5A, 0); send(7, 'h5A5, 0);
    send(9, 'hCCC, 1); settle();                 // R11 fifth rejected
    send(1, 'h00F, 1); settle();                 // R10 tally cleared
    send(4095, 'hFFF, 1); settle();              // R6 far out of range
    send(2046, 'h001, 0); send(1364, 'h321, 1); settle(); // R6 / R4 mix

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule